// File: doc/BRIEF.md
# Dual-Side GPIO Output Selector with Radio-State Table

This block owns two 16-pin general purpose I/O groups, one serving the receive side of a radio and one serving the transmit side. Each group has its own data, direction, source-select and debug-enable register. When a pin is an output, its value comes from one of four places. With the debug enable clear, it is either the software data register or a value taken from the radio-state table. With the debug enable set, it is one of two debug buses from the surrounding fabric.

The radio-state table stores eight words: for each of four radio states there is one word for the receive group and one for the transmit group. The live transmit and receive activity flags select the state, so table-driven pins follow the radio with no software involvement. Pads are modelled as an output value plus an output enable, with a separate input level that is sampled every cycle.

Software reaches the block over a simple 16-bit register bus with byte addresses. Address bit 0 is ignored, and every access is answered with a one-cycle acknowledge.

Top module: `gpio_atr_mux`

## Requirements
- R1: After reset, every register and every table word is zero, all output enables are low, the acknowledge is low and read data is zero.
- R2: A direction bit of 1 raises the output enable of that pin, starting the cycle after the write. Writing zero to a direction register releases all pins of that group. No other write changes an output enable.
- R3: A pin whose debug bit is 0 and select bit is 0 drives the value of its bit in the software data register.
- R4: A pin whose debug bit is 0 and select bit is 1 drives its bit of the radio-state table word for its group and the current state.
- R5: A pin whose debug bit is 1 drives debug bus 0 when its select bit is 0, and debug bus 1 when its select bit is 1.
- R6: Table words sit at byte address 0x10 + 4*state + 2*group, where group 0 is receive and group 1 is transmit. State 0 means no activity, 1 means transmit flag only, 2 means receive flag only and 3 means both flags. The state follows the flags combinationally, in the same cycle.
- R7: A read of a data register returns the pad input levels sampled on the previous clock edge, for input pins and output pins alike.
- R8: Register byte addresses are data 0x00, direction 0x04, select 0x08 and debug 0x0C for the receive group, each plus 2 for the transmit group. Direction, select, debug and table words read back the value last written.
- R9: Address bit 0 is ignored. A request that is accepted is acknowledged in the next cycle for exactly one cycle, and read data is valid while the acknowledge is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus request strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 5 | Byte address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, valid with acknowledge |
| bus_ack_o | output | 1 | Access acknowledge |
| tx_active_i | input | 1 | Transmit activity flag |
| rx_active_i | input | 1 | Receive activity flag |
| dbg0_rx_i | input | 16 | Debug bus 0, receive group |
| dbg0_tx_i | input | 16 | Debug bus 0, transmit group |
| dbg1_rx_i | input | 16 | Debug bus 1, receive group |
| dbg1_tx_i | input | 16 | Debug bus 1, transmit group |
| pad_rx_i | input | 16 | Receive group pad input levels |
| pad_rx_o | output | 16 | Receive group pad output values |
| pad_rx_oe_o | output | 16 | Receive group output enables |
| pad_tx_i | input | 16 | Transmit group pad input levels |
| pad_tx_o | output | 16 | Transmit group pad output values |
| pad_tx_oe_o | output | 16 | Transmit group output enables |

## Verification
The hardest case to reach from the ports is a pin whose value changes with no bus write at all: a table-driven pin that moves when only the activity flags change. The stimulus first loads all eight table words with distinct values that encode both state and group. It then holds the register contents fixed and steps the two flags through all four combinations, so that a wrong state decode or a swapped group shows up as a wrong word on the pads. Vectors that mix debug, select and direction bits within one word check that every pin picks its own source independently.

// File: rtl/gpio_atr_pkg.sv
package gpio_atr_pkg;
  localparam int unsigned ADDR_W     = 5;
  localparam int unsigned NUM_SIDES  = 2;
  localparam int unsigned NUM_STATES = 4;
  localparam int unsigned TABLE_WORDS = NUM_SIDES * NUM_STATES;
  localparam int unsigned TABLE_IDX_W = $clog2(TABLE_WORDS);

  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_DIR  = 2'd1,
    REG_SEL  = 2'd2,
    REG_DBG  = 2'd3
  } reg_kind_e;

  // word address = byte address >> 1
  typedef struct packed {
    logic       table_hit;
    logic [1:0] kind_state;
    logic       side;
  } word_addr_t;
endpackage

// File: rtl/gpio_bus_ctrl.sv
module gpio_bus_ctrl
  import gpio_atr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              wr_en_o,
  output logic              rd_en_o,
  output word_addr_t        word_o,
  output logic              ack_o
);
  logic ack_q;
  logic accept;
  logic unused_addr_lsb;

  assign unused_addr_lsb = addr_i[0];
  assign accept  = req_i && !ack_q;
  assign wr_en_o = accept && we_i;
  assign rd_en_o = accept && !we_i;
  assign word_o  = word_addr_t'(addr_i[ADDR_W-1:1]);
  assign ack_o   = ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= 1'b0;
    else         ack_q <= accept;
  end
endmodule

// File: rtl/gpio_atr_table.sv
module gpio_atr_table
  import gpio_atr_pkg::*;
#(
  parameter int unsigned PIN_W = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [TABLE_IDX_W-1:0] idx_i,
  input  logic [PIN_W-1:0]       wdata_i,
  input  logic                   tx_active_i,
  input  logic                   rx_active_i,
  output logic [PIN_W-1:0]       rd_word_o,
  output logic [PIN_W-1:0]       atr_rx_o,
  output logic [PIN_W-1:0]       atr_tx_o
);
  logic [PIN_W-1:0] words_q [TABLE_WORDS];
  logic [1:0]       state;

  // state 0 idle, 1 tx only, 2 rx only, 3 both
  assign state = {rx_active_i, tx_active_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < TABLE_WORDS; i++) words_q[i] <= '0;
    end else if (wr_en_i) begin
      words_q[idx_i] <= wdata_i;
    end
  end

  assign rd_word_o = words_q[idx_i];
  assign atr_rx_o  = words_q[{state, 1'b0}];
  assign atr_tx_o  = words_q[{state, 1'b1}];
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int unsigned PIN_W = 16
) (
  input  logic [PIN_W-1:0] sw_i,
  input  logic [PIN_W-1:0] atr_i,
  input  logic [PIN_W-1:0] dbg0_i,
  input  logic [PIN_W-1:0] dbg1_i,
  input  logic [PIN_W-1:0] sel_i,
  input  logic [PIN_W-1:0] dbg_en_i,
  output logic [PIN_W-1:0] out_o
);
  for (genvar p = 0; p < PIN_W; p++) begin : g_pin
    assign out_o[p] = dbg_en_i[p] ? (sel_i[p] ? dbg1_i[p] : dbg0_i[p])
                                  : (sel_i[p] ? atr_i[p]  : sw_i[p]);
  end
endmodule

// File: rtl/gpio_atr_mux.sv
module gpio_atr_mux
  import gpio_atr_pkg::*;
#(
  parameter int unsigned PIN_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [PIN_W-1:0]  bus_wdata_i,
  output logic [PIN_W-1:0]  bus_rdata_o,
  output logic              bus_ack_o,
  input  logic              tx_active_i,
  input  logic              rx_active_i,
  input  logic [PIN_W-1:0]  dbg0_rx_i,
  input  logic [PIN_W-1:0]  dbg0_tx_i,
  input  logic [PIN_W-1:0]  dbg1_rx_i,
  input  logic [PIN_W-1:0]  dbg1_tx_i,
  input  logic [PIN_W-1:0]  pad_rx_i,
  output logic [PIN_W-1:0]  pad_rx_o,
  output logic [PIN_W-1:0]  pad_rx_oe_o,
  input  logic [PIN_W-1:0]  pad_tx_i,
  output logic [PIN_W-1:0]  pad_tx_o,
  output logic [PIN_W-1:0]  pad_tx_oe_o
);
  logic       wr_en, rd_en;
  word_addr_t word;

  logic [PIN_W-1:0] data_q  [NUM_SIDES];
  logic [PIN_W-1:0] dir_q   [NUM_SIDES];
  logic [PIN_W-1:0] sel_q   [NUM_SIDES];
  logic [PIN_W-1:0] dbg_q   [NUM_SIDES];
  logic [PIN_W-1:0] pad_in_q[NUM_SIDES];
  logic [PIN_W-1:0] pad_in  [NUM_SIDES];
  logic [PIN_W-1:0] dbg0    [NUM_SIDES];
  logic [PIN_W-1:0] dbg1    [NUM_SIDES];
  logic [PIN_W-1:0] atr     [NUM_SIDES];
  logic [PIN_W-1:0] pad_out [NUM_SIDES];
  logic [PIN_W-1:0] table_rd, rd_word, rdata_q;

  assign pad_in[0] = pad_rx_i;
  assign pad_in[1] = pad_tx_i;
  assign dbg0[0]   = dbg0_rx_i;
  assign dbg0[1]   = dbg0_tx_i;
  assign dbg1[0]   = dbg1_rx_i;
  assign dbg1[1]   = dbg1_tx_i;

  gpio_bus_ctrl u_bus (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (bus_req_i),
    .we_i   (bus_we_i),
    .addr_i (bus_addr_i),
    .wr_en_o(wr_en),
    .rd_en_o(rd_en),
    .word_o (word),
    .ack_o  (bus_ack_o)
  );

  gpio_atr_table #(.PIN_W(PIN_W)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en && word.table_hit),
    .idx_i      ({word.kind_state, word.side}),
    .wdata_i    (bus_wdata_i),
    .tx_active_i(tx_active_i),
    .rx_active_i(rx_active_i),
    .rd_word_o  (table_rd),
    .atr_rx_o   (atr[0]),
    .atr_tx_o   (atr[1])
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NUM_SIDES; s++) begin
        data_q[s]   <= '0;
        dir_q[s]    <= '0;
        sel_q[s]    <= '0;
        dbg_q[s]    <= '0;
        pad_in_q[s] <= '0;
      end
    end else begin
      for (int s = 0; s < NUM_SIDES; s++) begin
        pad_in_q[s] <= pad_in[s];
        if (wr_en && !word.table_hit && (int'(word.side) == s)) begin
          unique case (reg_kind_e'(word.kind_state))
            REG_DATA: data_q[s] <= bus_wdata_i;
            REG_DIR:  dir_q[s]  <= bus_wdata_i;
            REG_SEL:  sel_q[s]  <= bus_wdata_i;
            REG_DBG:  dbg_q[s]  <= bus_wdata_i;
          endcase
        end
      end
    end
  end

  always_comb begin
    if (word.table_hit) rd_word = table_rd;
    else begin
      unique case (reg_kind_e'(word.kind_state))
        REG_DATA: rd_word = pad_in_q[word.side];
        REG_DIR:  rd_word = dir_q[word.side];
        REG_SEL:  rd_word = sel_q[word.side];
        default:  rd_word = dbg_q[word.side];
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_word;
  end
  assign bus_rdata_o = rdata_q;

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    gpio_pin_mux #(.PIN_W(PIN_W)) u_mux (
      .sw_i    (data_q[s]),
      .atr_i   (atr[s]),
      .dbg0_i  (dbg0[s]),
      .dbg1_i  (dbg1[s]),
      .sel_i   (sel_q[s]),
      .dbg_en_i(dbg_q[s]),
      .out_o   (pad_out[s])
    );
  end

  assign pad_rx_o    = pad_out[0];
  assign pad_tx_o    = pad_out[1];
  assign pad_rx_oe_o = dir_q[0];
  assign pad_tx_oe_o = dir_q[1];
endmodule

// File: rtl/gpio_atr_chk.sv
module gpio_atr_chk
  import gpio_atr_pkg::*;
#(
  parameter int unsigned PIN_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_req_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [PIN_W-1:0]  bus_wdata_i,
  input logic              bus_ack_o,
  input logic [PIN_W-1:0]  pad_rx_oe_o,
  input logic [PIN_W-1:0]  pad_tx_oe_o
);
  logic wr_acc, dir_rx_wr, dir_tx_wr;
  assign wr_acc    = bus_req_i && bus_we_i && !bus_ack_o;
  assign dir_rx_wr = wr_acc && (bus_addr_i[4:1] == 4'd2);
  assign dir_tx_wr = wr_acc && (bus_addr_i[4:1] == 4'd3);

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (pad_rx_oe_o == '0 && pad_tx_oe_o == '0 && !bus_ack_o)); // R1
  AST_ACK_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && !bus_ack_o) |=> bus_ack_o); // R9
  AST_ACK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_ack_o |=> !bus_ack_o); // R9
  AST_DIR_RX_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_rx_wr |=> (pad_rx_oe_o == $past(bus_wdata_i))); // R2
  AST_DIR_TX_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_tx_wr |=> (pad_tx_oe_o == $past(bus_wdata_i))); // R2
  AST_OE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dir_rx_wr || dir_tx_wr) |=> ($stable(pad_rx_oe_o) && $stable(pad_tx_oe_o))); // R2
endmodule

bind gpio_atr_mux gpio_atr_chk #(.PIN_W(PIN_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_req_i  (bus_req_i),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .bus_wdata_i(bus_wdata_i),
  .bus_ack_o  (bus_ack_o),
  .pad_rx_oe_o(pad_rx_oe_o),
  .pad_tx_oe_o(pad_tx_oe_o)
);

// File: tb/sim_gpio_atr_mux.sv
`timescale 1ns/1ps
module sim_gpio_atr_mux;
  localparam int W = 16;
  localparam logic [4:0] A_DATA_RX = 5'h00, A_DATA_TX = 5'h02,
                         A_DIR_RX  = 5'h04, A_DIR_TX  = 5'h06,
                         A_SEL_RX  = 5'h08, A_SEL_TX  = 5'h0A,
                         A_DBG_RX  = 5'h0C, A_DBG_TX  = 5'h0E;
  localparam logic [W-1:0] SW_RX = 16'h4321, SW_TX = 16'h1234;
  localparam logic [W-1:0] D0_RX = 16'hD0A5, D0_TX = 16'hD05A;
  localparam logic [W-1:0] D1_RX = 16'hE1C3, D1_TX = 16'hE13C;

  typedef struct packed {
    logic [W-1:0] dbg;
    logic [W-1:0] sel;
    logic [W-1:0] dir;
    logic         txa;
    logic         rxa;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{16'h0000, 16'h0000, 16'hFFFF, 1'b0, 1'b0},
    '{16'h0000, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0},
    '{16'h0000, 16'hFFFF, 16'hFFFF, 1'b1, 1'b0},
    '{16'h0000, 16'hFFFF, 16'hFFFF, 1'b0, 1'b1},
    '{16'h0000, 16'hFFFF, 16'hFFFF, 1'b1, 1'b1},
    '{16'hFFFF, 16'h0000, 16'hFFFF, 1'b0, 1'b0},
    '{16'hFFFF, 16'hFFFF, 16'h00FF, 1'b1, 1'b0},
    '{16'h0F0F, 16'h3C3C, 16'hA5A5, 1'b1, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [4:0] addr = '0;
  logic [W-1:0] wdata = '0, rdata;
  logic ack;
  logic txa = 1'b0, rxa = 1'b0;
  logic [W-1:0] pin_rx = '0, pin_tx = '0;
  logic [W-1:0] prx_o, prx_oe, ptx_o, ptx_oe;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_atr_mux u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .bus_ack_o(ack),
    .tx_active_i(txa), .rx_active_i(rxa),
    .dbg0_rx_i(D0_RX), .dbg0_tx_i(D0_TX), .dbg1_rx_i(D1_RX), .dbg1_tx_i(D1_TX),
    .pad_rx_i(pin_rx), .pad_rx_o(prx_o), .pad_rx_oe_o(prx_oe),
    .pad_tx_i(pin_tx), .pad_tx_o(ptx_o), .pad_tx_oe_o(ptx_oe)
  );

  function automatic logic [W-1:0] table_word(int st, int side);
    return 16'hA007 | W'(st << 8) | W'(side << 4);
  endfunction

  function automatic logic [4:0] table_addr(int st, int side);
    return 5'(16 + 4 * st + 2 * side);
  endfunction

  // expected pad value from R3..R6
  function automatic logic [W-1:0] exp_pad(int side, logic [W-1:0] dbg,
      logic [W-1:0] sel, logic t, logic r);
    logic [W-1:0] res, sw, d0, d1, tw;
    int st;
    st = (r ? 2 : 0) + (t ? 1 : 0);
    sw = side ? SW_TX : SW_RX;
    d0 = side ? D0_TX : D0_RX;
    d1 = side ? D1_TX : D1_RX;
    tw = table_word(st, side);
    for (int p = 0; p < W; p++)
      res[p] = dbg[p] ? (sel[p] ? d1[p] : d0[p]) : (sel[p] ? tw[p] : sw[p]);
    return res;
  endfunction

  task automatic check(string req_tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [4:0] a, input logic [W-1:0] d,
                     output logic [W-1:0] q, output logic ack_seen);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    ack_seen = ack;
    q = rdata;
  endtask

  task automatic wr(input logic [4:0] a, input logic [W-1:0] d);
    logic [W-1:0] q; logic k;
    bus(1'b1, a, d, q, k);
  endtask

  task automatic rd(input logic [4:0] a, output logic [W-1:0] q);
    logic k;
    bus(1'b0, a, '0, q, k);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] q;
    logic k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rx_oe", prx_oe, '0);
    check("R1 tx_oe", ptx_oe, '0);
    check("R1 ack", {15'b0, ack}, '0);
    check("R1 rdata", rdata, '0);
    rd(A_SEL_TX, q);  check("R1 sel_tx", q, '0);
    rd(table_addr(3, 1), q); check("R1 table", q, '0);

    // R9 ack timing
    bus(1'b0, A_DIR_RX, '0, q, k);
    check("R9 ack_high", {15'b0, k}, 16'd1);
    @(negedge clk);
    check("R9 ack_low", {15'b0, ack}, '0);

    // load data and table
    wr(A_DATA_RX, SW_RX);
    wr(A_DATA_TX, SW_TX);
    for (int st = 0; st < 4; st++)
      for (int sd = 0; sd < 2; sd++) wr(table_addr(st, sd), table_word(st, sd));
    rd(table_addr(2, 0), q); check("R8 table_rb", q, table_word(2, 0));
    rd(table_addr(1, 1), q); check("R6 table_rb", q, table_word(1, 1));

    // vector walk; rx group gets dbg/sel swapped
    for (int i = 0; i < NV; i++) begin
      wr(A_DBG_TX, VECS[i].dbg);
      wr(A_SEL_TX, VECS[i].sel);
      wr(A_DBG_RX, VECS[i].sel);
      wr(A_SEL_RX, VECS[i].dbg);
      wr(A_DIR_TX, VECS[i].dir);
      wr(A_DIR_RX, VECS[i].dir);
      @(negedge clk);
      txa = VECS[i].txa; rxa = VECS[i].rxa;
      #1;
      check("R3-R6 tx_pad R3 R4 R5 R6", ptx_o,
            exp_pad(1, VECS[i].dbg, VECS[i].sel, VECS[i].txa, VECS[i].rxa));
      check("R3-R6 rx_pad R3 R4 R5 R6", prx_o,
            exp_pad(0, VECS[i].sel, VECS[i].dbg, VECS[i].txa, VECS[i].rxa));
      check("R2 tx_oe", ptx_oe, VECS[i].dir);
      check("R2 rx_oe", prx_oe, VECS[i].dir);
    end

    // R6: flags alone move the table-driven pins, same cycle
    wr(A_DBG_TX, '0); wr(A_SEL_TX, 16'hFFFF);
    for (int st = 0; st < 4; st++) begin
      @(negedge clk);
      txa = st[0]; rxa = st[1];
      #1;
      check("R6 flag_step", ptx_o, table_word(st, 1));
    end

    // R8 readback of control registers
    rd(A_SEL_TX, q); check("R8 sel_tx_rb", q, 16'hFFFF);
    rd(A_DBG_RX, q); check("R8 dbg_rx_rb", q, VECS[NV-1].sel);

    // R9 odd address: bit 0 ignored
    wr(5'(A_DIR_TX | 5'h1), 16'h00F0);
    check("R9 odd_wr", ptx_oe, 16'h00F0);
    rd(5'(A_DIR_TX | 5'h1), q); check("R9 odd_rd", q, 16'h00F0);

    // R7 data read returns sampled pads, outputs and inputs alike
    @(negedge clk);
    pin_rx = 16'h5AA5; pin_tx = 16'h0FF0;
    rd(A_DATA_TX, q); check("R7 tx_pads", q, 16'h0FF0);
    wr(A_DIR_RX, '0);
    rd(A_DATA_RX, q); check("R7 rx_pads", q, 16'h5AA5);

    // R2 clearing direction releases every pin
    wr(A_DIR_TX, '0);
    check("R2 release_tx", ptx_oe, '0);
    check("R2 release_rx", prx_oe, '0);
    // R3: software data unchanged by reads, still drives when selected
    wr(A_SEL_TX, '0);
    @(negedge clk);
    check("R3 sw_hold", ptx_o, SW_TX);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule